// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block carries out 32x32 multiplication and 32/32 division, signed and unsigned, over many cycles. One iterative engine handles all four operations, one result bit per cycle. It writes its result into a pair of result registers, HI and LO. For a product, HI takes the upper 32 bits and LO the lower 32 bits. For a division, LO takes the quotient and HI takes the remainder. Both registers are visible at all times on two read outputs, so a move-from-HI or move-from-LO operation in the surrounding pipeline just samples the matching output.

Requests come in through a valid/ready handshake. A request is taken on a rising clock edge where `op_valid` and `op_ready` are both high. The operands and the operation code are captured on that edge, so they need not be held afterwards. `op_ready` stays low from that edge until HI and LO hold the new result. While it is low, the unit does not queue requests and applies no back-pressure: a request presented then is dropped, and the caller has to stall on `op_ready`. Reads made while the unit is busy return the previous result.

Signed operations run on operand magnitudes. The signs are applied in one correction cycle after the last iteration. Division by zero is not an error: it finishes in the normal time with a fixed result.

Top module: `mdu_unit`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `hi_q` and `lo_q` are zero and `op_ready` is high.
- R2: An accepted request drives `op_ready` low on the accepting edge. It stays low for exactly 33 cycles (W+1). HI and LO take the new result on the edge that raises `op_ready` again.
- R3: Operation code 2'b00 (signed multiply) produces the 64-bit two's-complement product of the operands. `hi_q` holds bits 63:32 and `lo_q` holds bits 31:0.
- R4: Operation code 2'b01 (unsigned multiply) produces the 64-bit unsigned product, split the same way as R3.
- R5: Operation code 2'b10 (signed divide) puts the quotient, truncated toward zero, in `lo_q`. It puts the remainder in `hi_q`, and the remainder takes the sign of the dividend.
- R6: Operation code 2'b11 (unsigned divide) treats both operands as natural numbers. The quotient goes to `lo_q` and the remainder to `hi_q`.
- R7: A divide with a zero divisor, signed or unsigned, finishes in the normal time. It leaves `lo_q` all ones and `hi_q` equal to the dividend.
- R8: While `op_ready` is low, `hi_q` and `lo_q` hold the previous result unchanged.
- R9: A request presented while `op_ready` is low is ignored. It changes neither the result nor the completion cycle of the operation in progress, and no new operation starts after it.
- R10: Signed divide of the most negative value by -1 gives `lo_q` = 32'h80000000 and `hi_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request valid |
| op_ready | output | 1 | Unit idle; a request is accepted when both are high |
| op_code | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| hi_q | output | 32 | HI register: product upper half or remainder |
| lo_q | output | 32 | LO register: product lower half or quotient |

## Verification
The bench targets the sign corners. It uses mixed-sign products, the most negative operand squared, and signed divides whose quotient and remainder must come out with different signs. A wrong correction stage would show up as a flipped remainder sign or an off-by-one product. A zero divisor and the most negative value divided by -1 expose a core that hangs, or that negates a quotient it should leave alone. After acceptance, the bench changes the operand inputs and pokes the unit with a second request. This catches a design that samples live inputs, accepts a request while busy, or lets HI/LO move before `op_ready` returns.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mdu_state_e;

  // sign handling decided at accept time, applied after the last iteration
  typedef struct packed {
    logic is_div;
    logic neg_lo;    // negate product / quotient
    logic neg_hi;    // negate remainder (divide only)
    logic div_zero;  // divisor was zero
  } mdu_ctl_t;

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_code,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output mdu_ctl_t     ctl
);

  logic is_signed;
  logic is_div;
  logic sgn_a;
  logic sgn_b;

  always_comb begin
    is_signed = ~op_code[0];
    is_div    = op_code[1];
    sgn_a     = is_signed & src_a[W-1];
    sgn_b     = is_signed & src_b[W-1];
    mag_a     = sgn_a ? (~src_a + 1'b1) : src_a;
    mag_b     = sgn_b ? (~src_b + 1'b1) : src_b;

    ctl.is_div   = is_div;
    ctl.neg_lo   = sgn_a ^ sgn_b;
    ctl.neg_hi   = is_div ? sgn_a : (sgn_a ^ sgn_b);
    ctl.div_zero = is_div & (src_b == '0);
  end

endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         is_div,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] acc,
  output logic [W-1:0] qr
);

  logic [W-1:0] dvs;
  logic [W-1:0] acc_n;
  logic [W-1:0] qr_n;

  // multiply: add-and-shift right over {acc, qr}
  logic [W:0]   mul_sum;
  // divide: restoring step over {acc, qr}, shifting left
  logic [W:0]   div_shift;
  logic [W+1:0] div_diff;

  always_comb begin
    mul_sum   = {1'b0, acc} + ({1'b0, dvs} & {(W+1){qr[0]}});
    div_shift = {acc, qr[W-1]};
    div_diff  = {1'b0, div_shift} - {2'b00, dvs};

    if (is_div) begin
      if (div_diff[W+1]) begin
        acc_n = div_shift[W-1:0];
        qr_n  = {qr[W-2:0], 1'b0};
      end else begin
        acc_n = div_diff[W-1:0];
        qr_n  = {qr[W-2:0], 1'b1};
      end
    end else begin
      acc_n = mul_sum[W:1];
      qr_n  = {mul_sum[0], qr[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      qr  <= '0;
      dvs <= '0;
    end else if (load) begin
      acc <= '0;
      qr  <= mag_a;
      dvs <= mag_b;
    end else if (step) begin
      acc <= acc_n;
      qr  <= qr_n;
    end
  end

endmodule

// File: rtl/mdu_sign_fix.sv
module mdu_sign_fix
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] qr,
  input  mdu_ctl_t     ctl,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);

  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_fix;

  always_comb begin
    prod     = {acc, qr};
    prod_fix = ctl.neg_lo ? (~prod + 1'b1) : prod;

    if (ctl.is_div) begin
      hi_n = ctl.neg_hi ? (~acc + 1'b1) : acc;
      if (ctl.div_zero)
        lo_n = '1;
      else
        lo_n = ctl.neg_lo ? (~qr + 1'b1) : qr;
    end else begin
      hi_n = prod_fix[2*W-1:W];
      lo_n = prod_fix[W-1:0];
    end
  end

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [1:0]   op_code,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  mdu_state_e     state;
  logic [CNT_W-1:0] cnt;
  mdu_ctl_t       ctl_in;
  mdu_ctl_t       ctl_r;
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic [W-1:0]   acc;
  logic [W-1:0]   qr;
  logic [W-1:0]   hi_n;
  logic [W-1:0]   lo_n;
  logic           accept;

  assign op_ready = (state == ST_IDLE);
  assign accept   = op_valid && op_ready;

  mdu_operand_prep #(.W(W)) u_prep (
    .op_code (op_code),
    .src_a   (src_a),
    .src_b   (src_b),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .ctl     (ctl_in)
  );

  mdu_iter_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (state == ST_RUN),
    .is_div (ctl_r.is_div),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .acc    (acc),
    .qr     (qr)
  );

  mdu_sign_fix #(.W(W)) u_fix (
    .acc  (acc),
    .qr   (qr),
    .ctl  (ctl_r),
    .hi_n (hi_n),
    .lo_n (lo_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ctl_r <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ctl_r <= ctl_in;
            cnt   <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_STEP)
            state <= ST_FIX;
        end
        ST_FIX: begin
          hi_q  <= hi_n;
          lo_q  <= lo_n;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic [1:0]   op_code,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);

  localparam int BW = $clog2(W + 2) + 1;

  logic [BW-1:0] busy_cnt;
  logic [1:0]    cap_op;
  logic [W-1:0]  cap_a;
  logic [W-1:0]  cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      cap_op   <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
    end else begin
      busy_cnt <= op_ready ? '0 : busy_cnt + 1'b1;
      if (op_valid && op_ready) begin
        cap_op <= op_code;
        cap_a  <= src_a;
        cap_b  <= src_b;
      end
    end
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_ready) |-> (busy_cnt == BW'(W + 1)));

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(op_ready) |-> ($stable(hi_q) && $stable(lo_q)));

  a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_ready) && cap_op[1] && (cap_b == '0)) |-> ((lo_q == '1) && (hi_q == cap_a)));

  a_r4_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_ready) && (cap_op == 2'b01)) |->
      ({hi_q, lo_q} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));

endmodule

bind mdu_unit mdu_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .src_a    (src_a),
  .src_b    (src_b),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/mdu_unit_test.sv
module mdu_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        op_ready;
  logic [31:0] hi_q;
  logic [31:0] lo_q;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdu_unit #(.W(32)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_code  (op_code),
    .src_a    (src_a),
    .src_b    (src_b),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
  );

  function automatic logic [63:0] model(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, p, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (c)
      2'b00: begin p = sa * sb; return p; end
      2'b01: return ua * ub;
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // issue one operation and follow it to completion
  task automatic run_op(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                        input string tag, input bit poke);
    logic [63:0] exp;
    logic [31:0] old_hi, old_lo;
    exp    = model(c, a, b);
    old_hi = hi_q;
    old_lo = lo_q;
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = c;
    src_a    = a;
    src_b    = b;
    @(negedge clk);
    op_valid = 1'b0;
    src_a    = $urandom;
    src_b    = $urandom;
    check1({tag, " R2 ready low after accept"}, op_ready, 1'b0);
    if (poke) begin
      // R9: second request while busy
      op_valid = 1'b1;
      op_code  = ~c;
      src_a    = 32'h0000_0005;
      src_b    = 32'h0000_0003;
      @(negedge clk);
      op_valid = 1'b0;
      repeat (31) @(negedge clk);
    end else begin
      repeat (32) @(negedge clk);
    end
    check1({tag, " R2 still busy at cycle 33"}, op_ready, 1'b0);
    check32({tag, " R8 stale HI while busy"}, hi_q, old_hi);
    check32({tag, " R8 stale LO while busy"}, lo_q, old_lo);
    @(negedge clk);
    check1({tag, " R2 ready back after 33 cycles"}, op_ready, 1'b1);
    check32({tag, " HI result"}, hi_q, exp[63:32]);
    check32({tag, " LO result"}, lo_q, exp[31:0]);
    if (poke) begin
      @(negedge clk);
      check1({tag, " R9 no op started by ignored request"}, op_ready, 1'b1);
      check32({tag, " R9 HI unchanged"}, hi_q, exp[63:32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check1("R1 ready in reset", op_ready, 1'b1);
    check32("R1 HI in reset", hi_q, 32'h0);
    check32("R1 LO in reset", lo_q, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R1 ready after reset", op_ready, 1'b1);
    check32("R1 HI after reset", hi_q, 32'h0);

    run_op(2'b00, 32'hFFFF_FFFD, 32'd7, "R3 neg*pos", 1'b0);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R3 min*min", 1'b0);
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 -1*-1", 1'b0);
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 max*max", 1'b0);
    run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R4 mixed", 1'b1);
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, "R5 -7/2", 1'b0);
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, "R5 7/-2", 1'b0);
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R10 min/-1", 1'b0);
    run_op(2'b11, 32'hFFFF_FFFF, 32'd3, "R6 max/3", 1'b0);
    run_op(2'b11, 32'd5, 32'd7, "R6 5/7", 1'b1);
    run_op(2'b10, 32'hFFFF_FFF7, 32'd0, "R7 signed by zero", 1'b0);
    run_op(2'b11, 32'd123, 32'd0, "R7 unsigned by zero", 1'b1);
    run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 -7/-2", 1'b0);

    for (int i = 0; i < 60; i++) begin
      logic [1:0]  c;
      logic [31:0] a, b;
      c = 2'($urandom);
      a = $urandom;
      b = $urandom;
      if (i % 4 == 1) b = b >> (b[4:0]);
      if (i % 7 == 3) a = a >> 20;
      run_op(c, a, b, $sformatf("%s random %0d", req_of(c), i), (i % 5 == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule